// File: doc/BRIEF.md
# Serial-Commanded Four-Channel Switch Controller

This block sits between a host's serial port and four output channels. The serial link runs at a far lower rate than the system clock. The block samples the serial clock, the chip select and the serial data with two-flop synchronisers, and it runs entirely on the system clock. Each chip-select frame carries one byte. The first four bits are a command nibble and the last four bits are channel data. The command is acted on at the rising edge of chip select.

The commands do three kinds of work. Some change the channel latches and the merge mode, which is an AND or an OR of the latched bits with four parallel inputs. A strap pin sets whether those parallel inputs are active high or active low. Other commands choose what the block returns in the following frame: a full two-bit status per channel, a read-back of the parallel input pins with one-bit fault flags, or a one-frame loop of serial input to serial output for testing the link. An active-low reset clears the shifter and the latches and holds every channel off.

Top module: `spi_quad_switch`

## Requirements
- R1: Serial input is sampled on falling SCLK, most significant bit first. Bits 7..4 are the command and bits 3..0 are data for channels 4..1, with bit 3 for channel 4 and 1 meaning ON. Latches and mode change only when chip select rises.
- R2: so_en is 1 exactly while cs_n is 0. Reply bits leave most significant bit first. Bit 7 is valid from the first rising SCLK, and each later rising SCLK presents the next bit.
- R3: Command 0000 leaves the latches and mode unchanged, and the next frame returns full status.
- R4: Full status is chan_stat[7:0] in the order channel 4..1. Each channel has 2 bits: 11 ok, 10 open load, 01 overload, 00 overtemperature.
- R5: Command 1100 leaves the latches unchanged. The next frame returns {par_in[3:0] as pin levels at the chip-select fall, F4..F1}, where Fn is 1 exactly when channel n's status is 11.
- R6: Command 1010 makes so follow si for the whole of the next frame only. The byte received in that frame is decoded as usual.
- R7: Command 0011 selects OR mode and 1111 selects AND mode. Either one latches data bits 3..0, and the next frame returns full status.
- R8: ch_out[n] is the effective input n merged with data latch n using the current mode. The effective input is par_in[n] when prg is 1 and ~par_in[n] when prg is 0.
- R9: Any other command nibble changes neither the latches nor the mode, and selects full status for the next frame.
- R10: A frame with a bit count other than eight leaves the latches and mode unchanged, and the next frame returns full status.
- R11: While rst_n is 0, ch_out is 0000. After release, the mode is OR, the data latches are 0 and the first reply is full status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select, one byte per frame |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid while so_en is 1 |
| so_en | output | 1 | Output enable for so (1 = drive, 0 = high impedance) |
| par_in | input | 4 | Parallel channel inputs, bit n for channel n+1 |
| prg | input | 1 | Polarity strap: 1 = parallel inputs active high |
| chan_stat | input | 8 | Two status bits per channel, channel 4 in [7:6] |
| ch_out | output | 4 | Channel on/off commands |

## Verification
The assertions assume the following about the inputs:
- sclk is low whenever cs_n changes.
- Every sclk and cs_n level lasts several system clocks, so the synchronised edges never merge.
- par_in, prg and chan_stat hold still during a frame.

The bench keeps within these limits. Each half period of sclk lasts eight system clocks. Status, strap and parallel inputs change only while chip select is high. Random commands, data and odd bit counts are then drawn inside those limits.

// File: rtl/spi_quad_switch.sv
module spi_quad_switch #(
  parameter int NCH = 4,
  parameter int FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             si,
  output logic             so,
  output logic             so_en,
  input  logic [NCH-1:0]   par_in,
  input  logic             prg,
  input  logic [2*NCH-1:0] chan_stat,
  output logic [NCH-1:0]   ch_out
);
  localparam int CW = $clog2(FRAME_BITS + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {RSP_DIAG, RSP_READ, RSP_ECHO} resp_t;

  logic [2:0] sclk_q, cs_q;
  logic [1:0] si_q;
  logic [FRAME_BITS-1:0] rx_q, tx_q, rsp_word;
  logic [CW-1:0] cnt_q;
  logic first_q, and_q;
  logic [NCH-1:0] data_q, fault_ok, eff_in;
  resp_t resp_q;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire cs_fall   = ~cs_q[1] & cs_q[2];
  wire cs_rise   = cs_q[1] & ~cs_q[2];
  wire cs_act    = ~cs_q[1];
  wire full_frame = (cnt_q == CW'(FRAME_BITS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      si_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      si_q   <= {si_q[0], si};
    end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign fault_ok[g] = &chan_stat[2*g +: 2];
    end
  endgenerate

  always_comb
    case (resp_q)
      RSP_READ: rsp_word = {par_in, fault_ok};
      RSP_DIAG: rsp_word = chan_stat;
      default:  rsp_word = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (cs_fall) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      tx_q    <= rsp_word;
    end else if (cs_act) begin
      if (sclk_fall) begin
        rx_q  <= {rx_q[FRAME_BITS-2:0], si_q[1]};
        cnt_q <= (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
      end
      if (sclk_rise) begin
        if (first_q) first_q <= 1'b0;
        else         tx_q    <= {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0;
      and_q  <= 1'b0;
      resp_q <= RSP_DIAG;
    end else if (cs_rise) begin
      resp_q <= RSP_DIAG;
      if (full_frame)
        case (rx_q[FRAME_BITS-1 -: 4])
          4'b1100: resp_q <= RSP_READ;
          4'b1010: resp_q <= RSP_ECHO;
          4'b0011: begin and_q <= 1'b0; data_q <= rx_q[NCH-1:0]; end
          4'b1111: begin and_q <= 1'b1; data_q <= rx_q[NCH-1:0]; end
          default: ;
        endcase
    end

  assign so_en  = ~cs_n;
  assign so     = (resp_q == RSP_ECHO) ? si : tx_q[FRAME_BITS-1];
  assign eff_in = prg ? par_in : ~par_in;
  assign ch_out = !rst_n ? '0 : (and_q ? (eff_in & data_q) : (eff_in | data_q));

  a_r1_latch_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(data_q) && $stable(and_q));
  a_r10_short_frame_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !full_frame |=> $stable(data_q) && $stable(and_q) && resp_q == RSP_DIAG);
  a_r6_echo_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
    resp_q == RSP_ECHO && cs_rise && !(full_frame && rx_q[FRAME_BITS-1 -: 4] == 4'b1010)
    |=> resp_q != RSP_ECHO);
  a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> cnt_q == '0 && first_q);
  a_r6_resp_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(resp_q));
endmodule

// File: tb/tb_spi_quad_switch.sv
module tb_spi_quad_switch;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, si = 0, prg = 1;
  logic [3:0] par_in = 4'h0;
  logic [7:0] chan_stat = 8'hFF;
  logic so, so_en;
  logic [3:0] ch_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_and = 0;
  logic [3:0] m_data = 0;
  int m_resp = 0;

  spi_quad_switch dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .so(so), .so_en(so_en), .par_in(par_in), .prg(prg), .chan_stat(chan_stat), .ch_out(ch_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ch();
    logic [3:0] e = prg ? par_in : ~par_in;
    return m_and ? (e & m_data) : (e | m_data);
  endfunction

  function automatic logic [7:0] exp_reply(input logic [7:0] sent);
    logic [3:0] f;
    for (int i = 0; i < 4; i++) f[i] = &chan_stat[2*i +: 2];
    if (m_resp == 1) return {par_in, f};
    if (m_resp == 2) return sent;
    return chan_stat;
  endfunction

  task automatic frame(input logic [7:0] b, input int nbits, input string req);
    logic [7:0] got = 0, exp;
    exp = exp_reply(b);
    repeat (4) @(negedge clk);
    chk(so_en === 1'b0, "R2 idle hiz", {7'd0, so_en}, 8'd0);
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    chk(so_en === 1'b1, "R2 enabled", {7'd0, so_en}, 8'd1);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 8) ? b[7-i] : 1'b0;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      if (i < 8) got[7-i] = so;
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1;
    repeat (HALF) @(negedge clk);
    if (nbits == 8)
      chk(got === exp, req, got, exp);
    if (nbits == 8) begin
      m_resp = 0;
      case (b[7:4])
        4'b1100: m_resp = 1;
        4'b1010: m_resp = 2;
        4'b0011: begin m_and = 0; m_data = b[3:0]; end
        4'b1111: begin m_and = 1; m_data = b[3:0]; end
        default: ;
      endcase
    end else m_resp = 0;
    chk(ch_out === exp_ch(), "R8 channel outputs after frame", {4'd0, ch_out}, {4'd0, exp_ch()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    par_in = 4'hF;
    repeat (5) @(negedge clk);
    chk(ch_out === 4'h0, "R11 outputs off in reset", {4'd0, ch_out}, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(ch_out === 4'hF, "R11 OR mode default, prg high", {4'd0, ch_out}, 8'h0F);
    par_in = 4'h0;
    chan_stat = 8'b11_10_01_00;
    frame(8'h00, 8, "R11 first reply full status");
    frame(8'h0A, 8, "R3 R4 diag only reply");
    par_in = 4'b1001;
    frame(8'hC5, 8, "R4 status after diag");
    frame(8'h3A, 8, "R5 readback reply");
    frame(8'hA0, 8, "R7 reply after OR set");
    frame(8'h35, 8, "R6 echo frame decoded");
    frame(8'hF6, 8, "R7 reply after echo");
    prg = 0;
    frame(8'h50, 8, "R9 reply after AND set");
    frame(8'h3F, 7, "R10 short frame");
    frame(8'h00, 8, "R10 reply after short frame");
    frame(8'h30, 9, "R10 long frame");
    par_in = 4'b0110;
    frame(8'hC0, 8, "R1 R3 full status");
    frame(8'h00, 8, "R5 readback with prg low");
    chk(ch_out === exp_ch(), "R8 AND mode prg low", {4'd0, ch_out}, {4'd0, exp_ch()});

    for (int n = 0; n < 60; n++) begin
      logic [3:0] nib;
      int nb;
      case ($urandom % 6)
        0: nib = 4'b0000;
        1: nib = 4'b1100;
        2: nib = 4'b1010;
        3: nib = 4'b0011;
        4: nib = 4'b1111;
        default: nib = 4'($urandom);
      endcase
      nb = (($urandom % 8) == 0) ? (7 + 2 * ($urandom % 2)) : 8;
      par_in = 4'($urandom);
      prg = 1'($urandom);
      chan_stat = 8'($urandom);
      repeat (3) @(negedge clk);
      chk(ch_out === exp_ch(), "R8 parallel change", {4'd0, ch_out}, {4'd0, exp_ch()});
      frame({nib, 4'($urandom)}, nb, "R1 random frame reply");
    end

    par_in = 4'hF; prg = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(ch_out === 4'h0, "R11 reset forces off", {4'd0, ch_out}, 8'h00);
    rst_n = 1; m_and = 0; m_data = 0; m_resp = 0;
    repeat (3) @(negedge clk);
    par_in = 4'h2;
    frame(8'h00, 8, "R11 full status after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule